// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is a single-channel SPI master that moves one word per transfer. A 12-bit control word sets the transfer length (1 to 63 bits), the bit order, the idle level of the serial clock, and two independent edge selects. One picks the SCLK direction on which a new bit is launched on MOSI. The other picks the direction on which MISO is sampled. A one-cycle start strobe hands over the parallel transmit word. The engine then lowers the active-low chip select and drives the first bit on MOSI before SCLK moves. It runs the serial clock from the system clock through a fixed half-period divider. When the transfer ends, it raises chip select and pulses done. At that point the received word is available on a parallel output.

Only timing where the first bit is driven before the first edge is meaningful. The usable pairings are idle-low SCLK with sampling on rising edges, and idle-high SCLK with launching on rising edges. In both cases every bit is sampled half an SCLK period before the next one is launched. The control word is captured when a transfer is accepted. The control word and the transmit word may therefore change while a transfer is running.

Top module: `spi_shift_master`

## Requirements
- R1: While reset is held and afterwards until a transfer starts, cs_n is 1, done is 0 and rx_data is 0. While no transfer runs, sclk equals ctl_word[7], and an asynchronous reset during a transfer returns sclk to that level and cs_n to 1 at once.
- R2: A start pulse is accepted at a rising clk edge when start is 1, ctl_word[11] (enable) is 1 and no transfer is running. Accepting it captures these control word fields:
  - [5:0] length in bits
  - [6] MSB-first order
  - [7] SCLK idle level
  - [8] launch on rising edges
  - [10] sample on rising edges
  
  Bit 9 has no function.
- R3: cs_n falls at the clk edge that accepts start. From that edge MOSI carries the first transmit bit, and sclk does not change in that cycle.
- R4: SCLK toggles once every HALF_CYCLES clk cycles, starting HALF_CYCLES cycles after cs_n falls. A transfer of length L makes exactly 2·L edges, and cs_n stays low for 2·L·HALF_CYCLES cycles.
- R5: With bit 6 set, MOSI sends tx_data[L-1] down to tx_data[0]. With bit 6 clear, it sends tx_data[0] up to tx_data[L-1]. Bits of tx_data at L and above are never sent. A new bit is launched only on edges whose direction matches bit 8.
- R6: MISO is sampled on edges whose direction matches bit 10. The k-th sampled bit is placed where the k-th transmit bit was taken from, so the received word is right-aligned with zeros above bit L-1. With a valid pairing no edge both launches and samples.
- R7: The last SCLK edge returns sclk to its idle level. In the same cycle cs_n rises and done is 1 for exactly one cycle. This happens half an SCLK period after the last sample edge. rx_data then holds the received word until the next accepted start.
- R8: An accepted start with length 0 gives done = 1 in the next cycle, with cs_n kept at 1 and no SCLK edge.
- R9: A start with ctl_word[11] = 0 is ignored. cs_n stays 1, done stays 0 and sclk does not move.
- R10: A start pulse during a running transfer is ignored. Changes on ctl_word or tx_data during the transfer do not alter its bits, its edge count or its received word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 12 | Control word (enable, edge selects, idle level, order, length) |
| start | input | 1 | Start strobe, one cycle |
| tx_data | input | 64 | Parallel transmit word, right-aligned |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low chip select |
| rx_data | output | 64 | Parallel receive word, right-aligned |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The properties on idle SCLK and on the chip-select falling edge take for granted that ctl_word is steady around those points. The stimulus therefore sets the control word one full cycle before raising start, and holds it unchanged while the engine is idle. They also assume start is a one-cycle strobe, which is why the bench raises it only as a single-cycle pulse. The check that no edge both launches and samples applies only to the valid pairings, so the bench uses no other pairing. The one mid-transfer disturbance keeps the idle polarity bit unchanged.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  localparam int CTL_W  = 12;
  localparam int LEN_W  = 6;
  localparam int DATA_W = 1 << LEN_W;
  localparam int EDGE_W = LEN_W + 1;

  typedef struct packed {
    logic             en;
    logic             in_rise;
    logic             out_rise;
    logic             cpol;
    logic             msb_first;
    logic [LEN_W-1:0] len;
  } spi_cfg_t;

  // Field positions of the control word.
  function automatic spi_cfg_t ctl_decode(input logic [CTL_W-1:0] w);
    spi_cfg_t c;
    c.en        = w[11];
    c.in_rise   = w[10];
    c.out_rise  = w[8];
    c.cpol      = w[7];
    c.msb_first = w[6];
    c.len       = w[LEN_W-1:0];
    return c;
  endfunction

  // Word position of the k-th serial bit of a transfer of length len.
  function automatic logic [LEN_W-1:0] bit_slot(input logic [LEN_W-1:0] k,
                                                input logic [LEN_W-1:0] len,
                                                input logic             msb);
    return msb ? (len - LEN_W'(1) - k) : k;
  endfunction

  // Index of the final SCLK edge of a transfer (edges counted from 0).
  function automatic logic [EDGE_W-1:0] last_edge_idx(input logic [LEN_W-1:0] len);
    return {len, 1'b0} - EDGE_W'(1);
  endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int HALF_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == CNT_W'(HALF_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_bit_path.sv
module spi_bit_path
  import spi_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              launch,
  input  logic              sample,
  input  logic              msb_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [EDGE_W-1:0] tx_idx;
  logic [EDGE_W-1:0] rx_idx;
  logic [EDGE_W-1:0] tx_nxt;
  logic [LEN_W-1:0]  len_q;
  logic              msb_q;
  logic              mosi_q;
  logic              more_tx;
  logic              more_rx;

  assign tx_nxt  = tx_idx + EDGE_W'(1);
  assign more_tx = tx_nxt < {1'b0, len_q};
  assign more_rx = rx_idx < {1'b0, len_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      tx_idx <= '0;
      rx_idx <= '0;
      len_q  <= '0;
      msb_q  <= 1'b0;
      mosi_q <= 1'b0;
    end else if (load) begin
      tx_q   <= tx_word;
      rx_q   <= '0;
      tx_idx <= '0;
      rx_idx <= '0;
      len_q  <= len_in;
      msb_q  <= msb_in;
      mosi_q <= tx_word[bit_slot('0, len_in, msb_in)];
    end else begin
      if (launch && more_tx) begin
        tx_idx <= tx_nxt;
        mosi_q <= tx_q[bit_slot(tx_nxt[LEN_W-1:0], len_q, msb_q)];
      end
      if (sample && more_rx) begin
        rx_q[bit_slot(rx_idx[LEN_W-1:0], len_q, msb_q)] <= miso;
        rx_idx <= rx_idx + EDGE_W'(1);
      end
    end
  end

  assign mosi    = mosi_q;
  assign rx_word = rx_q;
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_shift_pkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic [DATA_W-1:0] rx_data,
  output logic              done
);
  spi_cfg_t          cfg_live;
  logic              busy_q;
  logic              sclk_q;
  logic              cs_n_q;
  logic              done_q;
  logic [EDGE_W-1:0] edge_cnt;
  logic [LEN_W-1:0]  len_q;
  logic              in_rise_q;
  logic              out_rise_q;

  // Named events, also observed by the checker.
  logic edge_tick;
  logic new_level;
  logic launch_ev;
  logic sample_ev;
  logic finish_ev;
  logic accept_ev;
  logic empty_ev;

  assign cfg_live  = ctl_decode(ctl_word);
  assign accept_ev = start && cfg_live.en && !busy_q && (cfg_live.len != '0);
  assign empty_ev  = start && cfg_live.en && !busy_q && (cfg_live.len == '0);
  assign new_level = ~sclk_q;
  assign launch_ev = edge_tick && (new_level == out_rise_q);
  assign sample_ev = edge_tick && (new_level == in_rise_q);
  assign finish_ev = edge_tick && (edge_cnt == last_edge_idx(len_q));

  spi_half_tick #(.HALF_CYCLES(HALF_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_q),
    .tick  (edge_tick)
  );

  spi_bit_path u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept_ev),
    .launch  (launch_ev),
    .sample  (sample_ev),
    .msb_in  (cfg_live.msb_first),
    .len_in  (cfg_live.len),
    .tx_word (tx_data),
    .miso    (miso),
    .mosi    (mosi),
    .rx_word (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      sclk_q     <= 1'b0;
      cs_n_q     <= 1'b1;
      done_q     <= 1'b0;
      edge_cnt   <= '0;
      len_q      <= '0;
      in_rise_q  <= 1'b0;
      out_rise_q <= 1'b0;
    end else begin
      done_q <= finish_ev || empty_ev;
      if (accept_ev) begin
        busy_q     <= 1'b1;
        cs_n_q     <= 1'b0;
        sclk_q     <= cfg_live.cpol;
        edge_cnt   <= '0;
        len_q      <= cfg_live.len;
        in_rise_q  <= cfg_live.in_rise;
        out_rise_q <= cfg_live.out_rise;
      end else if (edge_tick) begin
        sclk_q   <= new_level;
        edge_cnt <= edge_cnt + EDGE_W'(1);
        if (finish_ev) begin
          busy_q <= 1'b0;
          cs_n_q <= 1'b1;
        end
      end
    end
  end

  assign sclk = busy_q ? sclk_q : cfg_live.cpol;
  assign cs_n = cs_n_q;
  assign done = done_q;
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] ctl_word,
  input logic        start,
  input logic        sclk,
  input logic        cs_n,
  input logic        done,
  input logic        busy,
  input logic        launch_ev,
  input logic        sample_ev,
  input logic        in_rise,
  input logic        out_rise
);
  // R3: chip select only falls on an accepted start, with SCLK still.
  a_r3_select_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(start) && $past(ctl_word[11]) && !$past(busy)));
  a_r3_no_edge_at_select: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $stable(sclk));
  // R4: no SCLK movement while deselected with a steady control word.
  a_r4_idle_sclk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $stable(ctl_word)) |-> $stable(sclk));
  // R7: deselect coincides with done.
  a_r7_done_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);
  // R6: a valid pairing never launches and samples on one edge.
  a_r6_sample_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rise != out_rise) |-> !(launch_ev && sample_ev));
  // R8: zero length finishes at once without selecting.
  a_r8_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ctl_word[11] && ctl_word[5:0] == 6'd0) |=> (done && cs_n));
  // R9: disabled start does nothing.
  a_r9_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !ctl_word[11]) |=> (cs_n && !done));
endmodule

bind spi_shift_master spi_shift_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_word  (ctl_word),
  .start     (start),
  .sclk      (sclk),
  .cs_n      (cs_n),
  .done      (done),
  .busy      (busy_q),
  .launch_ev (launch_ev),
  .sample_ev (sample_ev),
  .in_rise   (in_rise_q),
  .out_rise  (out_rise_q)
);

// File: tb/test_spi_shift_master.sv
module test_spi_shift_master;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] ctl_word = 12'h000;
  logic        start = 1'b0;
  logic [63:0] tx_data = '0;
  logic        miso = 1'b0;
  logic        sclk, mosi, cs_n, done;
  logic [63:0] rx_data;

  int nchecks = 0;
  int nfails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_shift_master #(.HALF_CYCLES(HALF)) i_spi_shift_master (
    .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .start(start),
    .tx_data(tx_data), .miso(miso), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .rx_data(rx_data), .done(done));

  // ctl, tx, slave word
  localparam logic [139:0] VEC [6] = '{
    {12'hC48, 64'h00000000000000A5, 64'h000000000000003C},
    {12'hC10, 64'h0000000000001234, 64'h000000000000BEEF},
    {12'h9CC, 64'h000000000FFFF5A3, 64'hFFFFFFFFFFFF0F69},
    {12'h981, 64'h0000000000000001, 64'h0000000000000001},
    {12'hC7F, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210},
    {12'h985, 64'h000000000000001B, 64'h0000000000000016}
  };

  // Slave model state.
  int          s_len;
  bit          s_msb, s_in, s_out;
  logic [63:0] s_word, cap;
  int          krx, ktx, edges, low_cycles, done_cnt;
  bit          active = 0, ended = 0, done_at_end = 0;
  logic        sclk_prev = 1'b0, cs_prev = 1'b1;

  function automatic int slot_of(int k, int len, bit msb);
    if (msb) return len - 1 - k;
    return k;
  endfunction

  function automatic logic [63:0] low_mask(int len);
    return (64'd1 << len) - 64'd1;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (cs_prev && !cs_n) begin
      active = 1; edges = 0; krx = 0; ktx = 0; cap = '0; low_cycles = 0;
      miso = s_word[slot_of(0, s_len, s_msb)];
    end
    if (active && sclk !== sclk_prev) begin
      edges++;
      if (sclk == s_in && krx < s_len) begin
        cap[slot_of(krx, s_len, s_msb)] = mosi;
        krx++;
      end
      if (sclk == s_out) begin
        ktx++;
        if (ktx < s_len) miso = s_word[slot_of(ktx, s_len, s_msb)];
      end
    end
    if (!cs_n) low_cycles++;
    if (done) done_cnt++;
    if (active && !cs_prev && cs_n) begin
      active = 0; ended = 1; done_at_end = done;
    end
    sclk_prev = sclk;
    cs_prev   = cs_n;
  end

  task automatic launch(logic [11:0] ctl, logic [63:0] tx, logic [63:0] sw);
    s_len = int'(ctl[5:0]); s_msb = ctl[6]; s_in = ctl[10]; s_out = ctl[8];
    s_word = sw;
    @(negedge clk);
    ctl_word = ctl; tx_data = tx;
    @(negedge clk);
    ended = 0; done_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_xfer(logic [11:0] ctl, logic [63:0] tx, logic [63:0] sw, bit poke);
    int len;
    len = int'(ctl[5:0]);
    launch(ctl, tx, sw);
    if (poke) begin
      // R10: second start mid-transfer with other data, same idle level
      repeat (4) @(negedge clk);
      start = 1'b1; ctl_word = {ctl[11:6], 6'd3}; tx_data = ~tx;
      @(negedge clk);
      start = 1'b0; tx_data = 64'h5555_5555_5555_5555;
    end
    while (!ended) @(negedge clk);
    check("R6 rx word", rx_data, sw & low_mask(len));
    check("R5 mosi word", cap, tx & low_mask(len));
    check("R4 edge count", 64'(edges), 64'(2 * len));
    check("R4 select width", 64'(low_cycles), 64'(2 * len * HALF));
    check("R7 done at deselect", 64'(done_at_end), 64'd1);
    check("R7 idle sclk", 64'(sclk), 64'(ctl[7]));
    repeat (8) @(negedge clk);
    check("R7 done single", 64'(done_cnt), 64'd1);
    check("R7 rx held", rx_data, sw & low_mask(len));
    if (poke) check("R10 cs stays high", 64'(cs_n), 64'd1);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!finished) begin
      nchecks++; nfails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchecks, nfails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, idle level follows the control word
    ctl_word = 12'h080;
    repeat (3) @(negedge clk);
    check("R1 cs_n in reset", 64'(cs_n), 64'd1);
    check("R1 done in reset", 64'(done), 64'd0);
    check("R1 rx in reset", rx_data, 64'd0);
    check("R1 sclk idle high", 64'(sclk), 64'd1);
    ctl_word = 12'h000;
    @(negedge clk);
    check("R1 sclk idle low", 64'(sclk), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 cs_n after reset", 64'(cs_n), 64'd1);

    // R2 R3 R4 R5 R6 R7: table walk
    for (int i = 0; i < 6; i++)
      run_xfer(VEC[i][139:128], VEC[i][127:64], VEC[i][63:0], 1'b0);

    // R3: first bit on MOSI before any SCLK edge
    launch(12'hC48, 64'h0000_0000_0000_0081, 64'h0);
    check("R3 cs low at start", 64'(cs_n), 64'd0);
    check("R3 first bit predriven", 64'(mosi), 64'd1);
    check("R3 sclk not moved", 64'(sclk), 64'd0);
    while (!ended) @(negedge clk);
    repeat (4) @(negedge clk);

    // R10: start during transfer ignored
    run_xfer(12'hC48, 64'h0000_0000_0000_00C3, 64'h0000_0000_0000_0096, 1'b1);

    // R8: zero length
    launch(12'hC40, 64'hFF, 64'h0);
    check("R8 done next cycle", 64'(done), 64'd1);
    check("R8 cs stays high", 64'(cs_n), 64'd1);
    @(negedge clk);
    check("R8 done one cycle", 64'(done), 64'd0);
    check("R8 no sclk edge", 64'(sclk), 64'd0);

    // R9: enable clear
    begin
      int seen;
      seen = 0;
      launch(12'h448, 64'hA5, 64'h0);
      for (int c = 0; c < 12; c++) begin
        if (!cs_n || done || sclk) seen++;
        @(negedge clk);
      end
      check("R9 disabled start ignored", 64'(seen), 64'd0);
    end

    // R1: reset during a transfer (idle-high mode)
    launch(12'h9CC, 64'h123, 64'h0);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset cs_n", 64'(cs_n), 64'd1);
    check("R1 reset sclk idle", 64'(sclk), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    active = 0;
    run_xfer(VEC[0][139:128], VEC[0][127:64], VEC[0][63:0], 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchecks, nfails);
    $finish;
  end
endmodule